// File: doc/BRIEF.md
# External Memory Access Steering Controller

This block sits between a CPU's data-memory request port and two possible targets: a 1 KB on-chip RAM and an off-chip memory bus. An 8-bit mode register picks one of four routing modes, the bus style (shared address/data pins or separate pins) and, for the shared style, how long the address-latch-enable pulse lasts. The CPU issues one access at a time and waits on a ready flag.

Each request may carry a full 16-bit address or only an 8-bit one. For an 8-bit address the block supplies the upper byte. It takes that byte either from a page register or from an address-high latch register, depending on the mode. It then decides whether the resulting address is served on-chip, folding it modulo 1024, or sent to the external bus. For the external bus it runs the strobe sequence.

Top module: `xmem_router`

## Requirements
- R1: After reset the mode register reads 0x03 and the page and address-high latch registers read 0x00. `cpu_ready` is high, `ext_ale` is low, and `ext_rd_n` and `ext_wr_n` are high.
- R2: The register port selects with `reg_sel` as follows: 0 selects the mode register, 1 the page register, 2 the address-high latch, and 3 always reads 0x00. Mode register bits 7..5 always read zero and ignore writes. Bit 4 = 1 selects separate address and data pins. Bits 3..2 select the routing mode. Bits 1..0 set the ALE width.
- R3: Routing mode 00 sends every access on-chip with `ram_addr` equal to the effective address modulo 1024. In this mode an 8-bit address takes its upper byte from the page register.
- R4: Routing modes 01 and 10 send an effective address below 0x0400 on-chip and any address at or above 0x0400 off-chip.
- R5: For an 8-bit address, the upper byte comes from the address-high latch in modes 01 and 11 and from the page register in mode 10. That byte takes part in the split decision. A 16-bit address is used unchanged.
- R6: Routing mode 11 sends every access off-chip and never enables the on-chip RAM.
- R7: A multiplexed off-chip access (bit 4 = 0) runs three phases in order. First `ext_ale` is high for N cycles, then low for N cycles, where N = bits 1..0 + 1. During both of these phases `ext_ad_out` carries the address low byte with `ext_ad_oe` high. Finally one strobe cycle drives `ext_addr_hi` with the upper byte.
- R8: A non-multiplexed off-chip access (bit 4 = 1) never raises `ext_ale`. It is a single strobe cycle with the full address on `ext_addr_hi`/`ext_addr_lo`.
- R9: `cpu_ready` falls in the cycle after a request is accepted and rises once the transfer ends. An on-chip access keeps it low for 2 cycles, a multiplexed off-chip access for 2N+1 cycles and a non-multiplexed one for 1 cycle. Read data appears on `cpu_rdata` when `cpu_ready` rises: from the RAM for on-chip reads, and from `ext_ad_in` sampled in the strobe cycle for off-chip reads.
- R10: An off-chip write pulses `ext_wr_n` low with `ext_ad_out` equal to the write data and `ext_ad_oe` high. An off-chip read pulses `ext_rd_n` low with `ext_ad_oe` low.
- R11: An access uses the register values in force before its accept edge. A mode register write in the same cycle changes only later accesses.
- R12: A request raised while an access is in progress is ignored and does not start an access afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| cpu_req | input | 1 | Access request, accepted while `cpu_ready` is high |
| cpu_addr | input | 16 | CPU address |
| cpu_short | input | 1 | 1: only the low 8 address bits are supplied |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the last completed read |
| cpu_ready | output | 1 | High when idle and able to accept |
| ram_en | output | 1 | On-chip RAM enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 10 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM read data, one cycle after enable |
| ext_addr_hi | output | 8 | External address upper byte |
| ext_addr_lo | output | 8 | External address low byte (separate-pin style) |
| ext_ad_out | output | 8 | External address/data output |
| ext_ad_oe | output | 1 | Output enable for `ext_ad_out` |
| ext_ad_in | input | 8 | External data input |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
A write to the mode register and the acceptance of a CPU request can land on the same clock edge. The two then compete over which routing mode and ALE width the access uses. The bench provokes this by raising `cpu_req` and a mode-register write in the same cycle. It switches from external-only with the widest ALE to internal-only. It then judges by the bus activity: the access must still go off-chip with four-cycle ALE phases, and only the following access to the same address must land in the on-chip RAM. A second collision, a request raised mid-access, is judged by checking that the bus address stays that of the first access and that no access follows.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    MODE_ONCHIP      = 2'b00,
    MODE_SPLIT_LATCH = 2'b01,
    MODE_SPLIT_PAGE  = 2'b10,
    MODE_OFFCHIP     = 2'b11
  } route_mode_e;

  typedef struct packed {
    logic [2:0]  rsvd;
    logic        demux;
    route_mode_e mode;
    logic [1:0]  ale_w;
  } mode_reg_t;

  localparam logic [7:0] MODE_REG_RESET = 8'h03;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_PAGE  = 2'd1;
  localparam logic [1:0] SEL_LATCH = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAM,
    ST_RAM_CAP,
    ST_ALE_HI,
    ST_ALE_LO,
    ST_STROBE
  } seq_state_e;

endpackage

// File: rtl/xmem_rst_sync.sv
module xmem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/xmem_cfg_regs.sv
module xmem_cfg_regs
  import xmem_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_sel,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output mode_reg_t       mode_q,
  output logic [HI_W-1:0] page_q,
  output logic [HI_W-1:0] latch_q
);
  mode_reg_t       mode_d;
  logic [HI_W-1:0] page_d, latch_d;
  logic            mode_en, page_en, latch_en;

  assign mode_en  = reg_wr && (reg_sel == SEL_MODE);
  assign page_en  = reg_wr && (reg_sel == SEL_PAGE);
  assign latch_en = reg_wr && (reg_sel == SEL_LATCH);

  always_comb begin
    mode_d  = mode_q;
    page_d  = page_q;
    latch_d = latch_q;
    if (mode_en) begin
      mode_d       = mode_reg_t'(reg_wdata);
      mode_d.rsvd  = 3'b000;
    end
    if (page_en)  page_d  = reg_wdata[HI_W-1:0];
    if (latch_en) latch_d = reg_wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= mode_reg_t'(MODE_REG_RESET);
      page_q  <= '0;
      latch_q <= '0;
    end else begin
      mode_q  <= mode_d;
      page_q  <= page_d;
      latch_q <= latch_d;
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_MODE:  reg_rdata = mode_q;
      SEL_PAGE:  reg_rdata = 8'(page_q);
      SEL_LATCH: reg_rdata = 8'(latch_q);
      default:   reg_rdata = 8'h00;
    endcase
  end

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> (mode_q == {3'b000, $past(reg_wdata[4:0])}));

  assert_page_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !page_en |=> $stable(page_q));
endmodule

// File: rtl/xmem_addr_decode.sv
module xmem_addr_decode
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RAM_BYTES = 1024
) (
  input  route_mode_e              mode,
  input  logic                     short_addr,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [ADDR_W-9:0]        page,
  input  logic [ADDR_W-9:0]        latch,
  output logic [ADDR_W-1:0]        eff_addr,
  output logic                     offchip
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] SPLIT_AT = ADDR_W'(RAM_BYTES);

  logic [HI_W-1:0] hi_src;

  always_comb begin
    unique case (mode)
      MODE_ONCHIP, MODE_SPLIT_PAGE: hi_src = page;
      default:                      hi_src = latch;
    endcase
  end

  assign eff_addr = short_addr ? {hi_src, cpu_addr[7:0]} : cpu_addr;

  always_comb begin
    unique case (mode)
      MODE_ONCHIP:  offchip = 1'b0;
      MODE_OFFCHIP: offchip = 1'b1;
      default:      offchip = (eff_addr >= SPLIT_AT);
    endcase
  end
endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              offchip,
  input  logic              cfg_demux,
  input  logic [1:0]        cfg_ale_w,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-9:0] ext_addr_hi,
  output logic [7:0]        ext_addr_lo,
  output logic [DATA_W-1:0] ext_ad_out,
  output logic              ext_ad_oe,
  input  logic [DATA_W-1:0] ext_ad_in,
  output logic              ext_ale,
  output logic              ext_rd_n,
  output logic              ext_wr_n
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q, demux_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d;
  logic [1:0]        width_q, cnt_q, cnt_d;
  logic              accept, load_req, rdata_en;
  logic              in_ale, in_strobe, in_ext;

  assign accept   = cpu_req && (state_q == ST_IDLE);
  assign load_req = accept;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    rdata_d  = rdata_q;
    rdata_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          cnt_d = cfg_ale_w;
          if (!offchip)      state_d = ST_RAM;
          else if (cfg_demux) state_d = ST_STROBE;
          else               state_d = ST_ALE_HI;
        end
      end
      ST_RAM:     state_d = ST_RAM_CAP;
      ST_RAM_CAP: begin
        rdata_en = !we_q;
        rdata_d  = ram_rdata;
        state_d  = ST_IDLE;
      end
      ST_ALE_HI: begin
        if (cnt_q == 2'd0) begin
          cnt_d   = width_q;
          state_d = ST_ALE_LO;
        end else begin
          cnt_d = cnt_q - 2'd1;
        end
      end
      ST_ALE_LO: begin
        if (cnt_q == 2'd0) state_d = ST_STROBE;
        else               cnt_d   = cnt_q - 2'd1;
      end
      ST_STROBE: begin
        rdata_en = !we_q;
        rdata_d  = ext_ad_in;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rdata_q <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      demux_q <= 1'b0;
      width_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (rdata_en) rdata_q <= rdata_d;
      if (load_req) begin
        addr_q  <= eff_addr;
        we_q    <= cpu_we;
        wdata_q <= cpu_wdata;
        demux_q <= cfg_demux;
        width_q <= cfg_ale_w;
      end
    end
  end

  assign in_ale    = (state_q == ST_ALE_HI) || (state_q == ST_ALE_LO);
  assign in_strobe = (state_q == ST_STROBE);
  assign in_ext    = in_ale || in_strobe;

  assign cpu_ready = (state_q == ST_IDLE);
  assign cpu_rdata = rdata_q;

  assign ram_en    = (state_q == ST_RAM);
  assign ram_we    = ram_en && we_q;
  assign ram_addr  = addr_q[RAM_AW-1:0];
  assign ram_wdata = wdata_q;

  assign ext_ale     = (state_q == ST_ALE_HI);
  assign ext_rd_n    = !(in_strobe && !we_q);
  assign ext_wr_n    = !(in_strobe && we_q);
  assign ext_addr_hi = in_ext ? addr_q[ADDR_W-1:8] : '0;
  assign ext_addr_lo = (in_strobe && demux_q) ? addr_q[7:0] : 8'h00;

  always_comb begin
    ext_ad_out = '0;
    ext_ad_oe  = 1'b0;
    if (in_ale) begin
      ext_ad_out = DATA_W'(addr_q[7:0]);
      ext_ad_oe  = 1'b1;
    end else if (in_strobe && we_q) begin
      ext_ad_out = wdata_q;
      ext_ad_oe  = 1'b1;
    end
  end

  // checker state: length of the current ALE high run
  logic [2:0] ale_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ale_run_q <= '0;
    else if (ext_ale) ale_run_q <= ale_run_q + 3'd1;
    else              ale_run_q <= '0;
  end

  assert_ale_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_ale) |-> (ale_run_q == ({1'b0, width_q} + 3'd1)));

  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!ext_rd_n, !ext_wr_n, ext_ale, ram_en}));

  assert_demux_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && offchip && cfg_demux) |=> (!ext_rd_n || !ext_wr_n));

  assert_offchip_no_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && offchip) |=> !ram_en);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cpu_ready);

  assert_addr_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ready && !$rose(ext_ale) && in_ext) |-> $stable(ext_addr_hi) || $past(cpu_ready));
endmodule

// File: rtl/xmem_router.sv
module xmem_router
  import xmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int RAM_BYTES = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                cpu_req,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_short,
  input  logic                cpu_we,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                ram_en,
  output logic                ram_we,
  output logic [$clog2(RAM_BYTES)-1:0] ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic [ADDR_W-9:0]   ext_addr_hi,
  output logic [7:0]          ext_addr_lo,
  output logic [DATA_W-1:0]   ext_ad_out,
  output logic                ext_ad_oe,
  input  logic [DATA_W-1:0]   ext_ad_in,
  output logic                ext_ale,
  output logic                ext_rd_n,
  output logic                ext_wr_n
);
  localparam int RAM_AW = $clog2(RAM_BYTES);
  localparam int HI_W   = ADDR_W - 8;

  logic              rst_n_sync;
  mode_reg_t         mode_q;
  logic [HI_W-1:0]   page_q, latch_q;
  logic [ADDR_W-1:0] eff_addr;
  logic              offchip;

  xmem_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xmem_cfg_regs #(.HI_W(HI_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mode_q    (mode_q),
    .page_q    (page_q),
    .latch_q   (latch_q)
  );

  xmem_addr_decode #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES)) u_dec (
    .mode       (mode_q.mode),
    .short_addr (cpu_short),
    .cpu_addr   (cpu_addr),
    .page       (page_q),
    .latch      (latch_q),
    .eff_addr   (eff_addr),
    .offchip    (offchip)
  );

  xmem_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_wdata   (cpu_wdata),
    .eff_addr    (eff_addr),
    .offchip     (offchip),
    .cfg_demux   (mode_q.demux),
    .cfg_ale_w   (mode_q.ale_w),
    .cpu_ready   (cpu_ready),
    .cpu_rdata   (cpu_rdata),
    .ram_en      (ram_en),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .ram_rdata   (ram_rdata),
    .ext_addr_hi (ext_addr_hi),
    .ext_addr_lo (ext_addr_lo),
    .ext_ad_out  (ext_ad_out),
    .ext_ad_oe   (ext_ad_oe),
    .ext_ad_in   (ext_ad_in),
    .ext_ale     (ext_ale),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n)
  );

  assert_internal_only_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cpu_req && cpu_ready && mode_q.mode == MODE_ONCHIP) |=> ram_en);
endmodule

// File: tb/tb_xmem_router.sv
module tb_xmem_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        cpu_req, cpu_short, cpu_we, cpu_ready;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        ram_en, ram_we;
  logic [9:0]  ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [7:0]  ext_addr_hi, ext_addr_lo, ext_ad_out, ext_ad_in;
  logic        ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_router dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_short(cpu_short), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata),
    .ext_addr_hi(ext_addr_hi), .ext_addr_lo(ext_addr_lo), .ext_ad_out(ext_ad_out),
    .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in), .ext_ale(ext_ale),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  // on-chip RAM model, one cycle read latency
  logic [7:0] mem [1024];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  // observations of one access
  int         obs_busy, obs_ram, obs_strobe, obs_ale_hi, obs_ale_lo;
  logic [9:0] obs_ram_addr;
  logic       obs_ram_we, obs_wrs, obs_oe;
  logic [7:0] obs_ram_wd, obs_ad_lo, obs_hi, obs_lo, obs_dout, obs_rdata;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, input string req, input logic [7:0] exp);
    @(negedge clk);
    reg_sel = sel;
    #1;
    chk(reg_rdata == exp, req, "register read", reg_rdata, exp);
  endtask

  task automatic do_access(input logic sh, input logic [15:0] a, input logic we,
                           input logic [7:0] wd, input logic [7:0] ein,
                           input logic cfgw, input logic [7:0] cfgv, input logic poke);
    obs_busy = 0; obs_ram = 0; obs_strobe = 0; obs_ale_hi = 0; obs_ale_lo = 0;
    ext_ad_in = ein;
    @(negedge clk);
    cpu_req = 1'b1; cpu_short = sh; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
    if (cfgw) begin reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = cfgv; end
    @(negedge clk);
    cpu_req = 1'b0; reg_wr = 1'b0; cpu_addr = 16'h0000;
    while (!cpu_ready && obs_busy < 40) begin
      if (ram_en) begin
        obs_ram++; obs_ram_addr = ram_addr; obs_ram_we = ram_we; obs_ram_wd = ram_wdata;
      end
      if (ext_ale) begin
        if (obs_ale_hi == 0) obs_ad_lo = ext_ad_out;
        obs_ale_hi++;
      end else if (obs_ale_hi > 0 && ext_rd_n && ext_wr_n) begin
        obs_ale_lo++;
      end
      if (!ext_rd_n || !ext_wr_n) begin
        obs_strobe++; obs_hi = ext_addr_hi; obs_lo = ext_addr_lo;
        obs_wrs = !ext_wr_n; obs_oe = ext_ad_oe; obs_dout = ext_ad_out;
      end
      obs_busy++;
      if (poke && obs_busy == 2) begin
        cpu_req = 1'b1; cpu_addr = 16'hBEEF; cpu_short = 1'b0;
      end else begin
        cpu_req = 1'b0;
      end
      @(negedge clk);
    end
    cpu_req = 1'b0;
    obs_rdata = cpu_rdata;
  endtask

  task automatic check_access(input string req, input logic off, input logic [15:0] ea,
                              input logic muxed, input int n, input logic we,
                              input logic [7:0] data);
    logic [15:0] got;
    if (!off) begin
      chk(obs_ram == 1 && obs_strobe == 0, req, "on-chip route", obs_strobe, 0);
      chk(obs_ram_addr == ea[9:0], req, "ram address", obs_ram_addr, ea[9:0]);
      chk(obs_busy == 2, req, "busy cycles", obs_busy, 2);
      if (we) chk(obs_ram_we && obs_ram_wd == data, req, "ram write data", obs_ram_wd, data);
      else    chk(obs_rdata == data, req, "read data", obs_rdata, data);
    end else begin
      chk(obs_ram == 0 && obs_strobe == 1, req, "off-chip route", obs_ram, 0);
      got = muxed ? {obs_hi, obs_ad_lo} : {obs_hi, obs_lo};
      chk(got == ea, req, "bus address", got, ea);
      chk(obs_ale_hi == (muxed ? n : 0), req, "ALE high cycles", obs_ale_hi, muxed ? n : 0);
      chk(obs_ale_lo == (muxed ? n : 0), req, "ALE low cycles", obs_ale_lo, muxed ? n : 0);
      chk(obs_busy == (muxed ? 2*n+1 : 1), req, "busy cycles", obs_busy, muxed ? 2*n+1 : 1);
      if (we) begin
        chk(obs_wrs && obs_oe && obs_dout == data, req, "write strobe data", obs_dout, data);
      end else begin
        chk(!obs_wrs && !obs_oe, req, "read strobe, oe low", obs_oe, 0);
        chk(obs_rdata == data, req, "read data", obs_rdata, data);
      end
    end
  endtask

  task automatic t_reset();
    rd_reg(2'd0, "R1", 8'h03);
    rd_reg(2'd1, "R1", 8'h00);
    rd_reg(2'd2, "R1", 8'h00);
    chk(cpu_ready && !ext_ale && ext_rd_n && ext_wr_n, "R1", "idle outputs",
        {cpu_ready, ext_ale, ext_rd_n, ext_wr_n}, 4'b1011);
  endtask

  task automatic t_regs();
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, "R2", 8'h1F);
    wr_reg(2'd3, 8'h77);
    rd_reg(2'd3, "R2", 8'h00);
    wr_reg(2'd1, 8'h12);
    wr_reg(2'd2, 8'h34);
    rd_reg(2'd1, "R2", 8'h12);
    rd_reg(2'd2, "R2", 8'h34);
  endtask

  task automatic t_internal();
    wr_reg(2'd0, 8'h00);
    do_access(1'b0, 16'h1C05, 1'b1, 8'hA1, 8'h00, 1'b0, 8'h00, 1'b0);
    check_access("R3", 1'b0, 16'h0005, 1'b0, 0, 1'b1, 8'hA1);
    do_access(1'b0, 16'h1E77, 1'b1, 8'h5C, 8'h00, 1'b0, 8'h00, 1'b0);
    do_access(1'b1, 16'h0077, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    check_access("R3_page_R9", 1'b0, 16'h1277, 1'b0, 0, 1'b0, 8'h5C);
  endtask

  task automatic t_split_latch();
    wr_reg(2'd0, 8'h04);
    do_access(1'b0, 16'h03FF, 1'b1, 8'h3C, 8'h00, 1'b0, 8'h00, 1'b0);
    do_access(1'b0, 16'h03FF, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    check_access("R4_below", 1'b0, 16'h03FF, 1'b0, 0, 1'b0, 8'h3C);
    do_access(1'b0, 16'h0400, 1'b0, 8'h00, 8'hC7, 1'b0, 8'h00, 1'b0);
    check_access("R4_at_R7_R10", 1'b1, 16'h0400, 1'b1, 1, 1'b0, 8'hC7);
    do_access(1'b1, 16'h0010, 1'b1, 8'h99, 8'h00, 1'b0, 8'h00, 1'b0);
    check_access("R5_latch_R10", 1'b1, 16'h3410, 1'b1, 1, 1'b1, 8'h99);
  endtask

  task automatic t_split_page();
    wr_reg(2'd0, 8'h18);
    do_access(1'b1, 16'h0020, 1'b0, 8'h00, 8'h6B, 1'b0, 8'h00, 1'b0);
    check_access("R5_page_R8", 1'b1, 16'h1220, 1'b0, 0, 1'b0, 8'h6B);
    wr_reg(2'd1, 8'h02);
    do_access(1'b1, 16'h0020, 1'b1, 8'h4E, 8'h00, 1'b0, 8'h00, 1'b0);
    check_access("R5_page_split_R4", 1'b0, 16'h0220, 1'b0, 0, 1'b1, 8'h4E);
  endtask

  task automatic t_external();
    wr_reg(2'd0, 8'h0F);
    do_access(1'b0, 16'h0010, 1'b0, 8'h00, 8'h2D, 1'b0, 8'h00, 1'b0);
    check_access("R6_R7_w4", 1'b1, 16'h0010, 1'b1, 4, 1'b0, 8'h2D);
    wr_reg(2'd0, 8'h0D);
    do_access(1'b1, 16'h0055, 1'b1, 8'hE2, 8'h00, 1'b0, 8'h00, 1'b0);
    check_access("R6_R5_latch_R7_w2", 1'b1, 16'h3455, 1'b1, 2, 1'b1, 8'hE2);
  endtask

  task automatic t_same_cycle_cfg();
    wr_reg(2'd0, 8'h0F);
    do_access(1'b0, 16'h0010, 1'b0, 8'h00, 8'h81, 1'b1, 8'h00, 1'b0);
    check_access("R11_old_mode", 1'b1, 16'h0010, 1'b1, 4, 1'b0, 8'h81);
    rd_reg(2'd0, "R11", 8'h00);
    do_access(1'b0, 16'h0010, 1'b1, 8'h17, 8'h00, 1'b0, 8'h00, 1'b0);
    check_access("R11_new_mode", 1'b0, 16'h0010, 1'b0, 0, 1'b1, 8'h17);
  endtask

  task automatic t_busy_req();
    int extra;
    wr_reg(2'd0, 8'h0E);
    do_access(1'b0, 16'h2468, 1'b0, 8'h00, 8'h3E, 1'b0, 8'h00, 1'b1);
    check_access("R12", 1'b1, 16'h2468, 1'b1, 3, 1'b0, 8'h3E);
    extra = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!cpu_ready || ram_en || ext_ale || !ext_rd_n || !ext_wr_n) extra++;
    end
    chk(extra == 0, "R12", "no access after busy request", extra, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    ram_rdata = 8'h00;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    cpu_req = 1'b0; cpu_addr = 16'h0000; cpu_short = 1'b0; cpu_we = 1'b0;
    cpu_wdata = 8'h00; ext_ad_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_internal();
    t_split_latch();
    t_split_page();
    t_external();
    t_same_cycle_cfg();
    t_busy_req();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule